// File: doc/BRIEF.md
# Prescaled Down-Counting Timer with Watchdog

This block is a general purpose timer built from two chained down-counters. A prescaler divides the clock by a programmable factor. Each time the prescaler wraps, a period counter steps down by one. Both reload values sit in one 32-bit count register. When the period counter runs out, the timer expires. The timer can then do one of three things:

- In one-shot mode it stops.
- In continuous mode it keeps running with the same period.
- In watchdog mode it emits a reset pulse. Software avoids that pulse by writing a service key before the count runs out.

A small register port reaches the mode word, the count word and a status word holding the expiry flag. Writes are byte-strobed and take effect on the clock edge where `bus_wr` is high. Reads return data one cycle after the address is presented.

Register addresses are 0 for mode, 1 for count and 2 for status. Mode word fields:

| Bit(s) | Meaning |
|--------|---------|
| 8 | interrupt enable |
| 10 | continuous |
| 12 | run |
| 15 | watchdog |
| 31:24 | service-key byte; writes only, always reads 0 |

All other mode bits read 0.

Top module: `prescaled_wdog_timer`

## Requirements
- R1: The count word holds the prescale value P in bits [31:16] and the period value C in bits [15:0]. A mode write, with strobe 1 set, that sets run bit 12 loads both counters. Expiry then occurs exactly P*C clocks after that write edge.
- R2: A prescale field of 0 divides by 65536. A period field of 0 counts 65536 prescaler wraps. A zero field never gives an immediate expiry.
- R3: With continuous bit 10 set, the counters reload on expiry and keep running. Each later expiry follows the previous one by P*C clocks.
- R4: Without bit 10 and without bit 15, the counter stops at expiry and run bit 12 reads back as 0.
- R5: Every expiry sets status bit 0. Output `irq` is high when that flag is set and interrupt enable bit 8 is set. Writing 1 to status bit 0 clears the flag, and `irq` falls on the same edge.
- R6: A mode write that sets watchdog bit 15 stores interrupt enable bit 8 as 0, whatever value was written to bit 8.
- R7: In watchdog mode, expiry drives `wdog_rst` high for one cycle, and the counter restarts with the same period.
- R8: In watchdog mode with run set, a write of 0xA5 to bits [31:24] with strobe 3 reloads both counters. Any other byte value has no effect. The key is also ignored when watchdog mode is off.
- R9: A mode write with bits 12 and 15 both 0 stops the timer and leaves watchdog mode, so no further `wdog_rst` pulse occurs.
- R10: After reset, all registers read 0 and `irq` and `wdog_rst` are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | clock |
| rst | input | 1 | synchronous active-high reset |
| bus_wr | input | 1 | write strobe |
| bus_waddr | input | 2 | write register select (0 mode, 1 count, 2 status) |
| bus_wdata | input | 32 | write data |
| bus_wstrb | input | 4 | byte enables for the write |
| bus_raddr | input | 2 | read register select |
| bus_rdata | output | 32 | registered read data, one cycle after the address |
| irq | output | 1 | expiry flag gated by interrupt enable |
| wdog_rst | output | 1 | one-cycle watchdog reset pulse |

## Verification
A wrong prescaler or period count shows as an expiry displaced from its P*C-clock position. The first `irq` or `wdog_rst` edge of a run therefore exposes it; no long soak is needed. A broken reload path shows on the second expiry, which arrives early or late, or stops arriving.

A wrong mode state shows on the next mode readback or on the gating of `irq`. Such states include a run bit left set after a one-shot, or an interrupt enable that survives watchdog entry. A service key that fails to reload the counters, or that reloads on a wrong key, moves the next reset pulse by a measurable number of cycles.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int BUS_W       = 32;
  localparam int BIT_IE      = 8;
  localparam int BIT_CONT    = 10;
  localparam int BIT_RUN     = 12;
  localparam int BIT_WD      = 15;
  localparam logic [7:0] SERVICE_KEY = 8'hA5;

  typedef enum logic [1:0] {
    A_MODE  = 2'd0,
    A_COUNT = 2'd1,
    A_STAT  = 2'd2
  } reg_addr_e;

  typedef struct packed {
    logic wd;
    logic run;
    logic cont;
    logic ie;
  } mode_t;
endpackage

// File: rtl/tmr_downcnt.sv
// Down-counter that reloads from its init value on wrap; init 0 means 2**W.
module tmr_downcnt #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic         step,
  input  logic [W-1:0] init,
  output logic         wrap
);
  localparam logic [W:0] FULL = {1'b1, {W{1'b0}}};
  localparam logic [W:0] ONE  = {{W{1'b0}}, 1'b1};

  logic [W:0] cnt;
  logic [W:0] start;

  assign start = (init == '0) ? FULL : {1'b0, init};
  assign wrap  = step && (cnt == ONE);

  always_ff @(posedge clk) begin
    if (rst)       cnt <= ONE;
    else if (load) cnt <= start;
    else if (step) cnt <= wrap ? start : cnt - ONE;
  end

  // R2: the counter stays within 1..2**W, so a zero field never fires at once
  assert_cnt_in_range_R2: assert property (@(posedge clk) disable iff (rst)
    (cnt != '0) && (cnt <= FULL));
endmodule

// File: rtl/tmr_ctrl.sv
// Register file and mode control for the timer.
module tmr_ctrl
  import tmr_pkg::*;
#(
  parameter int PRE_W = 16,
  parameter int PER_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [1:0]       wr_addr,
  input  logic [BUS_W-1:0] wr_data,
  input  logic [3:0]       wr_strb,
  input  logic [1:0]       rd_addr,
  input  logic             expire,
  output logic             run,
  output logic             load,
  output logic [PRE_W-1:0] pre_init,
  output logic [PER_W-1:0] per_init,
  output logic [BUS_W-1:0] rd_data,
  output logic             irq,
  output logic             wdog_rst
);
  localparam int NBYTES = BUS_W / 8;

  mode_t             m, m_n;
  logic [BUS_W-1:0]  cnt_reg;
  logic              flag, flag_n;
  logic              mode_wr, fld_wr, key_hit, service, clr_flag;
  logic [BUS_W-1:0]  mode_word;

  assign mode_wr  = wr_en && (wr_addr == A_MODE);
  assign fld_wr   = mode_wr && wr_strb[1];
  assign key_hit  = mode_wr && wr_strb[3] && (wr_data[31:24] == SERVICE_KEY);
  assign service  = key_hit && m.wd && m.run;
  assign clr_flag = wr_en && (wr_addr == A_STAT) && wr_strb[0] && wr_data[0];

  assign load     = (fld_wr && wr_data[BIT_RUN]) || service;
  assign run      = m.run;
  assign pre_init = cnt_reg[PER_W +: PRE_W];
  assign per_init = cnt_reg[PER_W-1:0];

  always_comb begin
    m_n = m;
    if (fld_wr) begin
      m_n.wd   = wr_data[BIT_WD];
      m_n.run  = wr_data[BIT_RUN];
      m_n.cont = wr_data[BIT_CONT];
      m_n.ie   = wr_data[BIT_IE] & ~wr_data[BIT_WD];
    end else if (expire && !m.wd && !m.cont) begin
      m_n.run = 1'b0;
    end
  end

  always_comb begin
    if (expire)        flag_n = 1'b1;
    else if (clr_flag) flag_n = 1'b0;
    else               flag_n = flag;
  end

  always_comb begin
    mode_word           = '0;
    mode_word[BIT_WD]   = m.wd;
    mode_word[BIT_RUN]  = m.run;
    mode_word[BIT_CONT] = m.cont;
    mode_word[BIT_IE]   = m.ie;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      m        <= '0;
      flag     <= 1'b0;
      irq      <= 1'b0;
      wdog_rst <= 1'b0;
    end else begin
      m        <= m_n;
      flag     <= flag_n;
      irq      <= flag_n & m_n.ie;
      wdog_rst <= expire & m.wd;
    end
  end

  for (genvar b = 0; b < NBYTES; b++) begin : g_cnt_byte
    always_ff @(posedge clk) begin
      if (rst)
        cnt_reg[8*b +: 8] <= '0;
      else if (wr_en && (wr_addr == A_COUNT) && wr_strb[b])
        cnt_reg[8*b +: 8] <= wr_data[8*b +: 8];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) rd_data <= '0;
    else begin
      case (rd_addr)
        A_MODE:  rd_data <= mode_word;
        A_COUNT: rd_data <= cnt_reg;
        A_STAT:  rd_data <= {{(BUS_W-1){1'b0}}, flag};
        default: rd_data <= '0;
      endcase
    end
  end

  // R6: watchdog mode never coexists with interrupt enable
  assert_wd_masks_ie_R6: assert property (@(posedge clk) disable iff (rst)
    m.wd |-> !m.ie);
  // R7: a reset pulse only follows a cycle spent in watchdog mode
  assert_pulse_from_wd_R7: assert property (@(posedge clk) disable iff (rst)
    wdog_rst |-> $past(m.wd));
  // R4: one-shot expiry without a competing mode write stops the counter
  assert_oneshot_stops_R4: assert property (@(posedge clk) disable iff (rst)
    (expire && !m.wd && !m.cont && !fld_wr) |=> !m.run);
  // R5: every expiry leaves the flag set
  assert_flag_on_expire_R5: assert property (@(posedge clk) disable iff (rst)
    expire |=> flag);
endmodule

// File: rtl/prescaled_wdog_timer.sv
module prescaled_wdog_timer
  import tmr_pkg::*;
#(
  parameter int PRE_W = 16,
  parameter int PER_W = 16
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        bus_wr,
  input  logic [1:0]  bus_waddr,
  input  logic [31:0] bus_wdata,
  input  logic [3:0]  bus_wstrb,
  input  logic [1:0]  bus_raddr,
  output logic [31:0] bus_rdata,
  output logic        irq,
  output logic        wdog_rst
);
  logic             run, load, pre_wrap, expire;
  logic [PRE_W-1:0] pre_init;
  logic [PER_W-1:0] per_init;

  tmr_ctrl #(.PRE_W(PRE_W), .PER_W(PER_W)) u_ctrl (
    .clk(clk), .rst(rst),
    .wr_en(bus_wr), .wr_addr(bus_waddr), .wr_data(bus_wdata), .wr_strb(bus_wstrb),
    .rd_addr(bus_raddr), .expire(expire),
    .run(run), .load(load), .pre_init(pre_init), .per_init(per_init),
    .rd_data(bus_rdata), .irq(irq), .wdog_rst(wdog_rst)
  );

  tmr_downcnt #(.W(PRE_W)) u_pre (
    .clk(clk), .rst(rst), .load(load), .step(run && !load),
    .init(pre_init), .wrap(pre_wrap)
  );

  tmr_downcnt #(.W(PER_W)) u_per (
    .clk(clk), .rst(rst), .load(load), .step(pre_wrap),
    .init(per_init), .wrap(expire)
  );
endmodule

// File: tb/prescaled_wdog_timer_tb.sv
module prescaled_wdog_timer_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_wr = 1'b0;
  logic [1:0]  bus_waddr = 2'd0;
  logic [31:0] bus_wdata = 32'd0;
  logic [3:0]  bus_wstrb = 4'd0;
  logic [1:0]  bus_raddr = 2'd0;
  logic [31:0] bus_rdata;
  logic        irq, wdog_rst;

  int total = 0;
  int bad   = 0;
  int cyc   = 0;

  localparam logic [31:0] M_IE = 32'h0000_0100, M_CONT = 32'h0000_0400,
                          M_RUN = 32'h0000_1000, M_WD = 32'h0000_8000;

  // {prescale, period, expected clocks to expiry}
  localparam logic [63:0] VEC [6] = '{
    {16'd1, 16'd1, 32'd1},
    {16'd1, 16'd5, 32'd5},
    {16'd3, 16'd4, 32'd12},
    {16'd7, 16'd3, 32'd21},
    {16'd0, 16'd1, 32'd65536},
    {16'd1, 16'd0, 32'd65536}
  };

  prescaled_wdog_timer u_dut (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_waddr(bus_waddr),
    .bus_wdata(bus_wdata), .bus_wstrb(bus_wstrb), .bus_raddr(bus_raddr),
    .bus_rdata(bus_rdata), .irq(irq), .wdog_rst(wdog_rst)
  );

  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d, input logic [3:0] s);
    bus_wr = 1'b1; bus_waddr = a; bus_wdata = d; bus_wstrb = s;
    @(posedge clk); @(negedge clk);
    bus_wr = 1'b0; bus_wstrb = 4'd0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] d);
    bus_raddr = a;
    @(posedge clk); @(negedge clk);
    d = bus_rdata;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin @(posedge clk); @(negedge clk); end
  endtask

  task automatic wait_ev(input bit sel_wd, input int lim, output int n, output bit seen);
    n = 0; seen = 1'b0;
    while (n < lim && !seen) begin
      @(posedge clk); @(negedge clk);
      n++;
      seen = sel_wd ? wdog_rst : irq;
    end
  endtask

  initial begin
    wait (cyc >= 190000);
    total++; bad++;
    $display("FAIL watchdog expired actual=%0d expected=<190000", cyc);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [31:0] d;
    int n;
    bit seen;

    idle(3);
    rst = 1'b0;
    @(negedge clk);

    // R10: reset state
    chk(!irq && !wdog_rst, "R10 outputs", {irq, wdog_rst}, 0);
    rd(2'd0, d); chk(d == 0, "R10 mode", d, 0);
    rd(2'd1, d); chk(d == 0, "R10 count", d, 0);
    rd(2'd2, d); chk(d == 0, "R10 status", d, 0);

    // R1 R2 R4 R5: one-shot vector table
    foreach (VEC[i]) begin
      wr(2'd1, VEC[i][63:32], 4'hF);
      wr(2'd0, M_RUN | M_IE, 4'h2);
      wait_ev(1'b0, int'(VEC[i][31:0]) + 5, n, seen);
      chk(seen && n == int'(VEC[i][31:0]), "R1/R2 expiry time", n, VEC[i][31:0]);
      rd(2'd0, d); chk(d == M_IE, "R4 run cleared", d, M_IE);
      rd(2'd2, d); chk(d == 1, "R5 flag set", d, 1);
      wr(2'd2, 32'd1, 4'h1);
      chk(!irq, "R5 irq cleared", irq, 0);
    end

    // R5: flag without interrupt enable keeps irq low
    wr(2'd1, {16'd1, 16'd2}, 4'hF);
    wr(2'd0, M_RUN, 4'h2);
    idle(4);
    chk(!irq, "R5 irq gated", irq, 0);
    rd(2'd2, d); chk(d == 1, "R5 flag without ie", d, 1);
    wr(2'd2, 32'd1, 4'h1);
    rd(2'd2, d); chk(d == 0, "R5 flag cleared", d, 0);

    // R3: continuous mode, second expiry P*C after the first
    wr(2'd1, {16'd2, 16'd3}, 4'hF);
    wr(2'd0, M_RUN | M_CONT | M_IE, 4'h2);
    wait_ev(1'b0, 20, n, seen);
    chk(seen && n == 6, "R3 first expiry", n, 6);
    wr(2'd2, 32'd1, 4'h1);
    wait_ev(1'b0, 20, n, seen);
    chk(seen && n == 5, "R3 second expiry", n, 5);
    rd(2'd0, d); chk(d[12] == 1'b1, "R3 still running", d, M_RUN | M_CONT | M_IE);
    wr(2'd0, 32'd0, 4'h2);
    wr(2'd2, 32'd1, 4'h1);

    // R8: key ignored outside watchdog mode
    wr(2'd1, {16'd1, 16'd8}, 4'hF);
    wr(2'd0, M_RUN | M_IE, 4'h2);
    idle(2);
    wr(2'd0, 32'hA500_0000, 4'h8);
    wait_ev(1'b0, 20, n, seen);
    chk(seen && n == 5, "R8 key ignored when not watchdog", n, 5);
    wr(2'd2, 32'd1, 4'h1);

    // R6 R7: watchdog expiry and pulse width
    wr(2'd1, {16'd1, 16'd10}, 4'hF);
    wr(2'd0, M_WD | M_RUN | M_IE, 4'h2);
    wait_ev(1'b1, 30, n, seen);
    chk(seen && n == 10, "R7 watchdog expiry", n, 10);
    idle(1);
    chk(!wdog_rst, "R7 one-cycle pulse", wdog_rst, 0);
    idle(3);
    // R8: service key reloads
    wr(2'd0, 32'hA500_0000, 4'h8);
    wait_ev(1'b1, 30, n, seen);
    chk(seen && n == 10, "R8 service reload", n, 10);
    // R8: wrong key has no effect; R7: counter restarted after pulse
    wr(2'd0, 32'h5A00_0000, 4'h8);
    wait_ev(1'b1, 30, n, seen);
    chk(seen && n == 9, "R8 wrong key ignored", n, 9);
    rd(2'd0, d); chk(d == (M_WD | M_RUN), "R6 ie forced low", d, M_WD | M_RUN);

    // R9: clearing run and watchdog bits stops it
    wr(2'd0, 32'd0, 4'h2);
    wait_ev(1'b1, 30, n, seen);
    chk(!seen, "R9 no pulse after stop", seen, 0);
    rd(2'd0, d); chk(d == 0, "R9 mode cleared", d, 0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule